// File: doc/BRIEF.md
# Watchdog Timer with Write-Unlocked Stop Control

This block is a free-running watchdog built around a 24-bit down-counter. Raising the run enable loads the counter from a reload word, after which it falls by one every clock. Software must keep it alive with a refresh strobe, which copies the reload word back in. If the counter reaches zero first, the block raises a timeout. A static mode input chooses the response. In interrupt mode the block emits a one-cycle request and the counter wraps to all-ones. In reset mode the block emits a reset request and the counter reloads.

A debug input holds the counter at its reload value, so a halted processor never trips it. A device-level stop input marks the low-power state. A stop-run setting decides whether the watchdog keeps counting while stopped. A reset-mode timeout during stop also requests a stop-mode recovery. The stop-run setting sits behind a control write port. It changes only after three writes in a row: 55h, then AAh, then a final byte. Status flags record a timeout and a timeout during stop, and a control read clears them.

Top module: `guard_timer`

## Requirements
- R1: After reset the count is 0, every pulse output and status flag is 0, and stop_run_en is 1, so the watchdog runs during stop by default.
- R2: On the first cycle that run_en is seen high after being low, the count takes reload_val. On each later active cycle it drops by one.
- R3: A refresh during an active cycle loads reload_val into the count. Counting down resumes on the following cycle.
- R4: While dbg_hold is high and the timer is active, the count stays at reload_val and no timeout is raised.
- R5: In interrupt mode (rst_mode = 0), an active cycle with count 0 causes three things on the next cycle: irq_pulse is high for exactly one cycle, sts_timeout is set, and the count becomes FFFFFFh and keeps counting down.
- R6: In reset mode (rst_mode = 1), a timeout causes three things on the next cycle: rst_req is high for one cycle, sts_timeout is set, and the count takes reload_val. If stop_state was high during the timeout cycle, stop_recover is also high and sts_stop is set.
- R7: The status flags stay set until a cycle with ctl_rd high clears them. They read 0 on the cycle after that.
- R8: Three consecutive control writes of 55h, AAh and then 81h clear stop_run_en. The sequence 55h, AAh, 00h sets it. The new value appears on the cycle after the third write.
- R9: Any write that breaks the 55h-then-AAh order sends the unlock sequencer back to idle. So does a third byte other than 81h or 00h. In both cases stop_run_en is left unchanged.
- R10: While stop_state is high and stop_run_en is 0, the count holds its value and no timeout occurs.
- R11: A reload value of zero gives a timeout on the clock right after the load.
- R12: While run_en is low, the count holds its value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Watchdog run enable; a rising level loads the counter |
| reload_val | input | 24 | Reload word |
| refresh | input | 1 | Refresh strobe |
| dbg_hold | input | 1 | Debug mode: keeps the counter refreshed |
| rst_mode | input | 1 | Timeout response: 0 interrupt, 1 reset |
| stop_state | input | 1 | Device is in the low-power stop state |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd | input | 1 | Control register read strobe; clears the status flags |
| irq_pulse | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| stop_recover | output | 1 | One-cycle stop-mode recovery request |
| sts_timeout | output | 1 | Sticky timeout flag |
| sts_stop | output | 1 | Sticky timeout-during-stop flag |
| stop_run_en | output | 1 | Watchdog runs during stop when 1 |
| count | output | 24 | Current counter value |

## Verification
The count register updates on the edge that samples a stimulus, so a load, refresh or decrement is visible one cycle after the input is driven. The response outputs and flags are registered from the cycle in which the count is zero. With a reload value N loaded at cycle L, the count reaches zero at L+N and the pulse appears at L+N+1. A write sequence ending at cycle W shows its effect on stop_run_en at W+1. Its effect on counting starts one cycle later. The driver computes each expected value's due cycle from these latencies and queues it. The monitor compares each item only at the falling edge of its due cycle, and it keeps running totals of request pulses to show that none occur in the hold windows.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] CODE_HALT  = 8'h81;
  localparam logic [7:0] CODE_RUN   = 8'h00;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_KEY1 = 2'd1,
    UL_KEY2 = 2'd2
  } unlock_st_t;
endpackage

// File: rtl/guard_unlock.sv
module guard_unlock
  import guard_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          stop_run_en
);
  unlock_st_t st_q, st_d;
  logic       run_d;

  always_comb begin
    st_d  = st_q;
    run_d = stop_run_en;
    if (wr) begin
      unique case (st_q)
        UL_IDLE: st_d = (wdata == KEY_FIRST)  ? UL_KEY1 : UL_IDLE;
        UL_KEY1: st_d = (wdata == KEY_SECOND) ? UL_KEY2 : UL_IDLE;
        UL_KEY2: begin
          st_d = UL_IDLE;
          if (wdata == CODE_HALT) run_d = 1'b0;
          else if (wdata == CODE_RUN) run_d = 1'b1;
        end
        default: st_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= UL_IDLE;
      stop_run_en <= 1'b1;
    end else begin
      st_q        <= st_d;
      stop_run_en <= run_d;
    end
  end

  // R9
  setting_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && st_q == UL_KEY2) |=> $stable(stop_run_en));
endmodule

// File: rtl/guard_count.sv
module guard_count #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] reload_val,
  input  logic          refresh,
  input  logic          dbg_hold,
  input  logic          rst_mode,
  input  logic          stop_state,
  input  logic          stop_run_en,
  output logic          tmo_evt,
  output logic [CW-1:0] count
);
  logic en_q, active, first_load, reload_cmd;
  logic [CW-1:0] count_d;

  function automatic logic [CW-1:0] next_value(
    input logic [CW-1:0] cur, input logic [CW-1:0] rld,
    input logic ld, input logic act, input logic tmo, input logic rmode);
    if (ld)        return rld;
    else if (tmo)  return rmode ? rld : {CW{1'b1}};
    else if (act)  return cur - 1'b1;
    else           return cur;
  endfunction

  assign active     = run_en && (!stop_state || stop_run_en);
  assign first_load = run_en && !en_q;
  assign reload_cmd = active && (refresh || dbg_hold);
  assign tmo_evt    = active && !first_load && !reload_cmd && (count == '0);
  assign count_d    = next_value(count, reload_val, first_load || reload_cmd,
                                 active, tmo_evt, rst_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      count <= '0;
    end else begin
      en_q  <= run_en;
      count <= count_d;
    end
  end

  // R5
  wrap_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !rst_mode) |=> (count == {CW{1'b1}}));
  // R4
  debug_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dbg_hold) |=> (count == $past(reload_val)));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && en_q) |=> $stable(count));
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] reload_val,
  input  logic          refresh,
  input  logic          dbg_hold,
  input  logic          rst_mode,
  input  logic          stop_state,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          ctl_rd,
  output logic          irq_pulse,
  output logic          rst_req,
  output logic          stop_recover,
  output logic          sts_timeout,
  output logic          sts_stop,
  output logic          stop_run_en,
  output logic [CW-1:0] count
);
  logic tmo_evt, stop_tmo;

  guard_unlock #(.DW(DW)) unlock_i (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .stop_run_en(stop_run_en));

  guard_count #(.CW(CW)) count_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_val(reload_val),
    .refresh(refresh), .dbg_hold(dbg_hold), .rst_mode(rst_mode),
    .stop_state(stop_state), .stop_run_en(stop_run_en),
    .tmo_evt(tmo_evt), .count(count));

  assign stop_tmo = tmo_evt && rst_mode && stop_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse    <= 1'b0;
      rst_req      <= 1'b0;
      stop_recover <= 1'b0;
      sts_timeout  <= 1'b0;
      sts_stop     <= 1'b0;
    end else begin
      irq_pulse    <= tmo_evt && !rst_mode;
      rst_req      <= tmo_evt && rst_mode;
      stop_recover <= stop_tmo;
      if (tmo_evt)     sts_timeout <= 1'b1;
      else if (ctl_rd) sts_timeout <= 1'b0;
      if (stop_tmo)    sts_stop <= 1'b1;
      else if (ctl_rd) sts_stop <= 1'b0;
    end
  end

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R6
  recover_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_recover |-> (rst_req && sts_stop));
  // R5
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> sts_timeout);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_timeout && !ctl_rd) |=> sts_timeout);
  // R10
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_state && !stop_run_en) |=> ($stable(count) && !irq_pulse && !rst_req));
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S_COUNT = 0, S_IRQ = 1, S_RST = 2, S_REC = 3, S_FT = 4,
                 S_FS = 5, S_SRE = 6, S_IRQTOT = 7, S_RSTTOT = 8;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       req;
  } item_t;

  logic clk = 0, rst_n = 0, run_en = 0, refresh = 0, dbg_hold = 0;
  logic rst_mode = 0, stop_state = 0, ctl_wr = 0, ctl_rd = 0;
  logic [23:0] reload_val = '0;
  logic [7:0]  ctl_wdata = '0;
  logic irq_pulse, rst_req, stop_recover, sts_timeout, sts_stop, stop_run_en;
  logic [23:0] count;

  item_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0, irq_total = 0, rst_total = 0;
  int base;

  guard_timer dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_val(reload_val),
    .refresh(refresh), .dbg_hold(dbg_hold), .rst_mode(rst_mode),
    .stop_state(stop_state), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rd(ctl_rd), .irq_pulse(irq_pulse), .rst_req(rst_req),
    .stop_recover(stop_recover), .sts_timeout(sts_timeout),
    .sts_stop(sts_stop), .stop_run_en(stop_run_en), .count(count));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [31:0] actual(input int sel);
    case (sel)
      S_COUNT:  return {8'h0, count};
      S_IRQ:    return {31'h0, irq_pulse};
      S_RST:    return {31'h0, rst_req};
      S_REC:    return {31'h0, stop_recover};
      S_FT:     return {31'h0, sts_timeout};
      S_FS:     return {31'h0, sts_stop};
      S_SRE:    return {31'h0, stop_run_en};
      S_IRQTOT: return irq_total;
      default:  return rst_total;
    endcase
  endfunction

  // monitor: pops items whose due cycle has arrived
  always @(negedge clk) begin
    if (irq_pulse) irq_total++;
    if (rst_req) rst_total++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_run++;
        if (actual(q[i].sel) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%0h expected=%0h",
                   q[i].req, q[i].sel, cyc, actual(q[i].sel), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(input int sel, input logic [31:0] val, input int dk, input string req);
    item_t it;
    it.due = cyc + dk; it.sel = sel; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [23:0] rv);
    run_en = 0; step(1);
    reload_val = rv; run_en = 1;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    ctl_wr = 1; ctl_wdata = d; step(1); ctl_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    // R1 reset state
    expect_at(S_COUNT, 0, 1, "R1"); expect_at(S_IRQ, 0, 1, "R1");
    expect_at(S_FT, 0, 1, "R1");    expect_at(S_FS, 0, 1, "R1");
    expect_at(S_SRE, 1, 1, "R1");   expect_at(S_RST, 0, 1, "R1");
    step(3);

    // R2 first enable loads then counts down
    reload_val = 24'd100; run_en = 1;
    expect_at(S_COUNT, 100, 1, "R2"); expect_at(S_COUNT, 95, 6, "R2");
    step(10);
    // R3 refresh reloads, resumes next cycle
    refresh = 1;
    expect_at(S_COUNT, 100, 1, "R3"); expect_at(S_COUNT, 99, 2, "R3");
    step(1); refresh = 0; step(5);

    // R4 debug hold
    dbg_hold = 1;
    expect_at(S_COUNT, 100, 1, "R4"); expect_at(S_COUNT, 100, 250, "R4");
    expect_at(S_IRQTOT, 0, 250, "R4");
    step(250); dbg_hold = 0;
    expect_at(S_COUNT, 98, 2, "R4");
    step(5);

    // R5 interrupt-mode timeout and wrap
    restart(24'd10);
    expect_at(S_COUNT, 0, 11, "R5");
    expect_at(S_IRQ, 1, 12, "R5"); expect_at(S_FT, 1, 12, "R5");
    expect_at(S_COUNT, 24'hFFFFFF, 12, "R5");
    expect_at(S_IRQ, 0, 13, "R5"); expect_at(S_COUNT, 24'hFFFFFE, 13, "R5");
    expect_at(S_IRQTOT, 1, 15, "R5");
    step(20);
    // R7 sticky until read
    expect_at(S_FT, 1, 0, "R7");
    ctl_rd = 1; expect_at(S_FT, 0, 1, "R7");
    step(1); ctl_rd = 0;
    expect_at(S_FT, 0, 5, "R7");
    step(6);

    // R6 reset-mode timeout, then one during stop
    rst_mode = 1;
    restart(24'd5);
    base = cyc;
    expect_at(S_RST, 1, 7, "R6"); expect_at(S_COUNT, 5, 7, "R6");
    expect_at(S_REC, 0, 7, "R6"); expect_at(S_FS, 0, 7, "R6");
    expect_at(S_FT, 1, 7, "R6");  expect_at(S_RST, 0, 8, "R6");
    step(8);
    stop_state = 1;
    expect_at(S_RST, 1, 5, "R6"); expect_at(S_REC, 1, 5, "R6");
    expect_at(S_FS, 1, 5, "R6");  expect_at(S_RSTTOT, 2, 7, "R6");
    step(8);
    ctl_rd = 1; expect_at(S_FS, 0, 1, "R7"); step(1); ctl_rd = 0;
    stop_state = 0; rst_mode = 0;

    // R8 unlock to stop counting in stop state
    restart(24'd50);
    step(1);
    wr_byte(8'h55); wr_byte(8'hAA);
    expect_at(S_SRE, 0, 1, "R8");
    wr_byte(8'h81);
    expect_at(S_COUNT, 47, 0, "R8");
    stop_state = 1;
    // R10 frozen while stopped with run disabled
    expect_at(S_COUNT, 47, 1, "R10"); expect_at(S_COUNT, 47, 20, "R10");
    expect_at(S_IRQTOT, 1, 20, "R10");
    step(3);
    // R9 broken sequences leave setting unchanged
    wr_byte(8'h55); wr_byte(8'h12); wr_byte(8'hAA); wr_byte(8'h00);
    expect_at(S_SRE, 0, 1, "R9");
    step(1);
    wr_byte(8'h55); wr_byte(8'hAA); wr_byte(8'h33);
    expect_at(S_SRE, 0, 1, "R9"); expect_at(S_COUNT, 47, 1, "R9");
    step(15);
    // R8 re-enable running in stop
    wr_byte(8'h55); wr_byte(8'hAA);
    expect_at(S_SRE, 1, 1, "R8"); expect_at(S_COUNT, 47, 1, "R8");
    expect_at(S_COUNT, 46, 2, "R8");
    wr_byte(8'h00);
    step(3);
    stop_state = 0;

    // R11 zero reload times out on the next clock
    restart(24'd0);
    base = irq_total;
    expect_at(S_COUNT, 0, 1, "R11"); expect_at(S_IRQ, 1, 2, "R11");
    expect_at(S_COUNT, 24'hFFFFFF, 2, "R11");
    step(3);
    // R12 disabled counter holds
    run_en = 0;
    expect_at(S_COUNT, 24'hFFFFFE, 1, "R12"); expect_at(S_COUNT, 24'hFFFFFE, 40, "R12");
    expect_at(S_IRQTOT, base + 1, 40, "R12");
    step(45);

    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard pending actual=%0d expected=0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule